// File: doc/BRIEF.md
# Incremental Dot-Product Distance Engine

This block produces the three dot products from which a squared Euclidean distance between two pixel vectors is formed. Each vector is 784 unsigned 8-bit pixels, delivered as 49 packets of 16 pixels (128 bits) over a valid/ready input. The first vector after a reset is the held (unlabelled) vector. It is written into an internal 784-byte store while its self-dot product accumulates. Each later vector is a stream (labelled) vector. Each of its packets adds to the stream self-dot product and to the cross-dot product against the matching 16-pixel slice of the held vector.

Each accepted packet is latched into a 16-byte register. The input then drops ready for one cycle while a 16-lane multiply-add folds the packet into the accumulators. A small register port reads the three 32-bit accumulators and a control/status word. Writing the soft-reset bit starts a new round by clearing the accumulators, rewinding the slice counter and re-entering priming.

Top module: `dotdist_engine`

## Requirements
- R1: After rst_ni is released, all three accumulators read 0 and the status word reads 3: free flag (bit 0) = 1, priming flag (bit 1) = 1, soft-reset bit (bit 2) = 0, vector-done flag (bit 3) = 0.
- R2: A packet is taken on a clock edge where pkt_valid_i and pkt_ready_o are both high. pkt_ready_o and status bit 0 are then low for exactly one cycle and high again after it.
- R3: While priming, each packet adds the sum of its 16 squared pixels to the held accumulator (address 0) and leaves the other two accumulators unchanged. Byte lane i (pkt_data_i[8i+7:8i]) of packet k is element 16k+i.
- R4: The priming flag stays 1 through the first 48 packets and reads 0 once the 49th packet has been accumulated.
- R5: After priming, packet k adds the sum of its squared pixels to the stream accumulator (address 1) and the sum of lane-wise products with held elements 16k..16k+15 to the cross accumulator (address 2). The held accumulator is unchanged.
- R6: The vector-done flag (status bit 3) rises when the 49th stream packet of a vector is accumulated and clears on the next accepted packet. The slice counter then wraps, so the next packet pairs with held slice 0.
- R7: A write to address 3 with bit 2 set clears all accumulators, the slice counter and the done flag, and sets the priming flag. A write with bit 2 clear, or to any other address, changes nothing. Bit 2 always reads 0.
- R8: When a soft reset and a packet handshake fall on the same edge, the soft reset wins: the packet is discarded, ready stays high and the accumulators read 0.
- R9: With every pixel 255, each of the three accumulators reaches 784*255*255 = 50979600 after a full vector, with no wrap.
- R10: reg_rdata_o returns, combinationally from reg_addr_i: 0 = held self-dot, 1 = stream self-dot, 2 = cross-dot, 3 = status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pkt_valid_i | input | 1 | Packet offered |
| pkt_ready_o | output | 1 | Engine can take a packet |
| pkt_data_i | input | 128 | 16 pixels, lane i in bits 8i+7:8i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 3 | Control write data (bit 2 = soft reset) |
| reg_rdata_o | output | 32 | Register read data |

## Verification
A soft-reset write can land on the same edge as a packet handshake. The bench provokes this by raising the register write and pkt_valid_i in the same cycle while ready is high. It then judges the outcome at the ports. Ready must still be high one cycle later and all accumulators must read zero with priming set. A fresh packet sent afterwards must land as priming packet 0, with its squared sum alone in the held accumulator.

// File: rtl/dotdist_pkg.sv
package dotdist_pkg;
  typedef enum logic [1:0] {
    ADDR_HELD   = 2'd0,
    ADDR_STREAM = 2'd1,
    ADDR_CROSS  = 2'd2,
    ADDR_CTRL   = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_W   = 3;
  localparam int unsigned ST_FREE  = 0;
  localparam int unsigned ST_PRIME = 1;
  localparam int unsigned ST_SRST  = 2;
  localparam int unsigned ST_DONE  = 3;
endpackage

// File: rtl/dotdist_mac.sv
module dotdist_mac #(
  parameter int unsigned LANES = 16,
  parameter int unsigned PIX_W = 8,
  parameter int unsigned ACC_W = 32
) (
  input  logic [LANES*PIX_W-1:0] a_i,
  input  logic [LANES*PIX_W-1:0] b_i,
  output logic [ACC_W-1:0]       sum_o
);
  localparam int unsigned PROD_W = 2 * PIX_W;

  logic [PROD_W-1:0] prod [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign prod[g] = PROD_W'(a_i[g*PIX_W +: PIX_W]) * PROD_W'(b_i[g*PIX_W +: PIX_W]);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < LANES; i++) sum_o = sum_o + ACC_W'(prod[i]);
  end
endmodule

// File: rtl/dotdist_slice_buf.sv
module dotdist_slice_buf #(
  parameter int unsigned PKTS  = 49,
  parameter int unsigned PKT_W = 128,
  localparam int unsigned CW   = $clog2(PKTS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [CW-1:0]    idx_i,
  input  logic [PKT_W-1:0] wdata_i,
  output logic [PKT_W-1:0] rdata_o
);
  logic [PKT_W-1:0] mem_q [PKTS];

  // storage is always written during priming before any read uses it
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/dotdist_ctrl.sv
module dotdist_ctrl #(
  parameter int unsigned PKTS = 49,
  localparam int unsigned CW  = $clog2(PKTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_clr_i,
  input  logic          accept_i,
  output logic [CW-1:0] cnt_o,
  output logic          priming_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          priming_q, busy_q, done_q, last;

  assign last = (cnt_q == CW'(PKTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      priming_q <= 1'b1;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else if (soft_clr_i) begin
      cnt_q     <= '0;
      priming_q <= 1'b1;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (accept_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end
      if (busy_q) begin
        busy_q <= 1'b0;
        cnt_q  <= last ? '0 : cnt_q + 1'b1;
        if (last) begin
          if (priming_q) priming_q <= 1'b0;
          else           done_q    <= 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign priming_o = priming_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  a_r6_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(PKTS));

  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(cnt_q) == CW'(PKTS - 1) && !priming_q));

  a_r4_prime_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priming_q && busy_q && last && !soft_clr_i) |=> !priming_q);

  a_r2_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q);
endmodule

// File: rtl/dotdist_engine.sv
module dotdist_engine
  import dotdist_pkg::*;
#(
  parameter int unsigned LANES   = 16,
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned VEC_LEN = 784,
  parameter int unsigned ACC_W   = 32,
  localparam int unsigned PKT_W  = LANES * PIX_W,
  localparam int unsigned PKTS   = VEC_LEN / LANES,
  localparam int unsigned CW     = $clog2(PKTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [PKT_W-1:0]  pkt_data_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [ACC_W-1:0]  reg_rdata_o
);
  logic             accept, soft_clr;
  logic [CW-1:0]    cnt;
  logic             priming, busy, done;
  logic [PKT_W-1:0] pkt_q, slice;
  logic [ACC_W-1:0] self_dot, cross_dot;
  logic [ACC_W-1:0] acc_held_q, acc_stream_q, acc_cross_q;

  assign pkt_ready_o = !busy;
  assign accept      = pkt_valid_i && pkt_ready_o;
  assign soft_clr    = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_CTRL) && reg_wdata_i[ST_SRST];

  dotdist_ctrl #(.PKTS(PKTS)) u_ctrl (
    .clk_i, .rst_ni,
    .soft_clr_i(soft_clr),
    .accept_i  (accept),
    .cnt_o     (cnt),
    .priming_o (priming),
    .busy_o    (busy),
    .done_o    (done)
  );

  dotdist_slice_buf #(.PKTS(PKTS), .PKT_W(PKT_W)) u_buf (
    .clk_i,
    .we_i   (accept && priming && !soft_clr),
    .idx_i  (cnt),
    .wdata_i(pkt_data_i),
    .rdata_o(slice)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pkt_q <= '0;
    else if (accept) pkt_q <= pkt_data_i;
  end

  dotdist_mac #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W)) u_mac_self (
    .a_i(pkt_q), .b_i(pkt_q), .sum_o(self_dot)
  );

  dotdist_mac #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W)) u_mac_cross (
    .a_i(pkt_q), .b_i(slice), .sum_o(cross_dot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_held_q   <= '0;
      acc_stream_q <= '0;
      acc_cross_q  <= '0;
    end else if (soft_clr) begin
      acc_held_q   <= '0;
      acc_stream_q <= '0;
      acc_cross_q  <= '0;
    end else if (busy) begin
      if (priming) begin
        acc_held_q <= acc_held_q + self_dot;
      end else begin
        acc_stream_q <= acc_stream_q + self_dot;
        acc_cross_q  <= acc_cross_q + cross_dot;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_HELD:   reg_rdata_o = acc_held_q;
      ADDR_STREAM: reg_rdata_o = acc_stream_q;
      ADDR_CROSS:  reg_rdata_o = acc_cross_q;
      default: begin
        reg_rdata_o           = '0;
        reg_rdata_o[ST_FREE]  = !busy;
        reg_rdata_o[ST_PRIME] = priming;
        reg_rdata_o[ST_DONE]  = done;
      end
    endcase
  end

  a_r2_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !soft_clr) |=> !pkt_ready_o);

  a_r5_held_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!priming && !soft_clr) |=> $stable(acc_held_q));

  a_r3_stream_idle_priming: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priming && !soft_clr) |=> ($stable(acc_stream_q) && $stable(acc_cross_q)));

  a_r7_soft_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr |=> (acc_held_q == '0 && acc_stream_q == '0 && acc_cross_q == '0
                  && priming && pkt_ready_o));
endmodule

// File: tb/dotdist_engine_bench.sv
module dotdist_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PKTS  = 49;
  localparam int LANES = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pkt_valid = 1'b0;
  logic         pkt_ready;
  logic [127:0] pkt_data = '0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [2:0]   reg_wdata = 3'd0;
  logic [31:0]  reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dotdist_engine u_dotdist_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready), .pkt_data_i(pkt_data),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata)
  );

  function automatic int held_px(int e);  return (e * 7 + 3) & 255;   endfunction
  function automatic int strm_px(int e);  return (e * 13 + 100) & 255; endfunction

  function automatic logic [127:0] make_pkt(int k, bit held, bit all_ff);
    logic [127:0] p;
    for (int i = 0; i < LANES; i++)
      p[8*i +: 8] = all_ff ? 8'hFF : 8'(held ? held_px(16*k+i) : strm_px(16*k+i));
    return p;
  endfunction

  task automatic check(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic check_reg(string req, logic [1:0] a, longint exp);
    logic [31:0] d;
    read_reg(a, d);
    check(req, d, exp);
  endtask

  // drive at negedge; returns at the negedge after accumulation
  task automatic send_pkt(logic [127:0] p);
    @(negedge clk);
    while (!pkt_ready) @(negedge clk);
    pkt_valid = 1'b1;
    pkt_data  = p;
    @(negedge clk);
    pkt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_reg(logic [1:0] a, logic [2:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 3'd0;
  endtask

  longint exp_held, exp_strm, exp_cross;

  task automatic t_reset;
    check_reg("R1 held", 2'd0, 0);
    check_reg("R1 stream", 2'd1, 0);
    check_reg("R1 cross", 2'd2, 0);
    check_reg("R1 status", 2'd3, 3);
    check("R1 ready", pkt_ready, 1);
  endtask

  task automatic t_handshake;
    logic [127:0] p;
    p = make_pkt(0, 1'b1, 1'b0);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_data = p;
    @(negedge clk);
    pkt_valid = 1'b0;
    check("R2 ready low", pkt_ready, 0);
    check_reg("R2 status free low", 2'd3, 2);
    @(negedge clk);
    check("R2 ready back", pkt_ready, 1);
    exp_held = 0;
    for (int i = 0; i < LANES; i++) exp_held += held_px(i) * held_px(i);
    check_reg("R3 held pkt0", 2'd0, exp_held);
    check_reg("R3 stream untouched", 2'd1, 0);
    check_reg("R3 cross untouched", 2'd2, 0);
  endtask

  task automatic t_ignored_writes;
    write_reg(2'd3, 3'b011);
    write_reg(2'd0, 3'b100);
    check_reg("R7 ignored held", 2'd0, exp_held);
    check_reg("R7 ignored status", 2'd3, 3);
  endtask

  task automatic t_finish_priming;
    for (int k = 1; k < PKTS - 1; k++) send_pkt(make_pkt(k, 1'b1, 1'b0));
    check_reg("R4 still priming at 48", 2'd3, 3);
    send_pkt(make_pkt(PKTS - 1, 1'b1, 1'b0));
    check_reg("R4 priming off", 2'd3, 1);
    exp_held = 0;
    for (int e = 0; e < 784; e++) exp_held += held_px(e) * held_px(e);
    check_reg("R3 held total", 2'd0, exp_held);
  endtask

  task automatic t_stream_vector;
    for (int k = 0; k < PKTS - 1; k++) send_pkt(make_pkt(k, 1'b0, 1'b0));
    check_reg("R6 not done at 48", 2'd3, 1);
    send_pkt(make_pkt(PKTS - 1, 1'b0, 1'b0));
    check_reg("R6 done", 2'd3, 9);
    exp_strm = 0; exp_cross = 0;
    for (int e = 0; e < 784; e++) begin
      exp_strm  += strm_px(e) * strm_px(e);
      exp_cross += strm_px(e) * held_px(e);
    end
    check_reg("R5 stream", 2'd1, exp_strm);
    check_reg("R5 cross", 2'd2, exp_cross);
    check_reg("R5 held frozen", 2'd0, exp_held);
  endtask

  task automatic t_wrap;
    send_pkt(make_pkt(0, 1'b0, 1'b0));
    check_reg("R6 done cleared", 2'd3, 1);
    for (int i = 0; i < LANES; i++) begin
      exp_strm  += strm_px(i) * strm_px(i);
      exp_cross += strm_px(i) * held_px(i);
    end
    check_reg("R6 wrap stream", 2'd1, exp_strm);
    check_reg("R6 wrap cross slice0", 2'd2, exp_cross);
  endtask

  task automatic t_soft_reset;
    write_reg(2'd3, 3'b100);
    check_reg("R7 held clr", 2'd0, 0);
    check_reg("R7 stream clr", 2'd1, 0);
    check_reg("R7 cross clr", 2'd2, 0);
    check_reg("R7 status", 2'd3, 3);
  endtask

  task automatic t_collision;
    logic [127:0] p;
    longint s;
    send_pkt(make_pkt(5, 1'b1, 1'b0));
    @(negedge clk);
    pkt_valid = 1'b1; pkt_data = make_pkt(7, 1'b1, 1'b0);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 3'b100;
    @(negedge clk);
    pkt_valid = 1'b0; reg_wr = 1'b0; reg_wdata = 3'd0;
    check("R8 ready stays high", pkt_ready, 1);
    check_reg("R8 held zero", 2'd0, 0);
    check_reg("R8 status", 2'd3, 3);
    p = make_pkt(3, 1'b0, 1'b0);
    send_pkt(p);
    s = 0;
    for (int i = 0; i < LANES; i++) s += p[8*i +: 8] * p[8*i +: 8];
    check_reg("R8 fresh pkt as pkt0", 2'd0, s);
  endtask

  task automatic t_worst_case;
    write_reg(2'd3, 3'b100);
    for (int k = 0; k < PKTS; k++) send_pkt(make_pkt(k, 1'b1, 1'b1));
    for (int k = 0; k < PKTS; k++) send_pkt(make_pkt(k, 1'b0, 1'b1));
    check_reg("R9 held max", 2'd0, 50979600);
    check_reg("R9 stream max", 2'd1, 50979600);
    check_reg("R9 cross max", 2'd2, 50979600);
    check_reg("R10 status map", 2'd3, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_handshake();
    t_ignored_writes();
    t_finish_priming();
    t_stream_vector();
    t_wrap();
    t_soft_reset();
    t_collision();
    t_worst_case();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule